// File: doc/BRIEF.md
# SPI Byte Memory Command Sequencer

This block is the slave side of a four-wire serial link in front of an 8192-byte memory. Bytes travel most significant bit first. The block accepts both clock idle levels in which data is sampled on rising clock edges and shifted out on falling edges. The serial pins are oversampled in the system clock domain, so a synchronizer stage and an edge detector feed a command sequencer. The sequencer takes one command byte per selection. For memory commands it collects a two-byte address, then streams bytes into or out of an on-chip array. Each stored byte commits as soon as its eighth bit arrives, and the byte address steps after every byte and wraps at the end of the array.

Storage of the status byte and the write-protection policy live in a neighbouring unit. The sequencer sends that unit pulses for latch set and clear, status writes and the end of a write command. It reads the status byte from that unit, and for every memory byte it asks through a combinational grant input whether the byte may be stored. A hold input can pause a transfer at any bit and resume it later without losing its place.

Sequencer states: `ST_OPCODE` (waiting for the command byte), `ST_ADDR_HI`, `ST_ADDR_LO`, `ST_MEM_WR`, `ST_MEM_RD`, `ST_STAT_RD`, `ST_STAT_WR` and `ST_IGNORE` (the rest of the selection is discarded). The transitions are as follows. Any deselect returns the sequencer to `ST_OPCODE`. On a completed byte in `ST_OPCODE`, a memory read or write code leads to `ST_ADDR_HI`, a status read to `ST_STAT_RD`, a status write to `ST_STAT_WR`, and every other code to `ST_IGNORE`. `ST_ADDR_HI` then leads to `ST_ADDR_LO`, and `ST_ADDR_LO` leads to `ST_MEM_WR` or `ST_MEM_RD`, which repeat on each byte. `ST_STAT_RD` and `ST_STAT_WR` lead to `ST_IGNORE` after one byte, and `ST_IGNORE` stays where it is.

Top module: `spi_mem_ctrl`

## Requirements
- R1: Command codes are decoded from the first byte of a selection. 0x06 gives one `wel_set_stb` pulse and 0x04 gives one `wel_clr_stb` pulse, each on the eighth rising clock edge. 0x05 is status read, 0x01 is status write, 0x03 is memory read and 0x02 is memory write. Any other code has no effect.
- R2: A selection carries exactly one command. Bytes sent after a command has finished cause no pulse, no memory change and no output drive.
- R3: The block works with the serial clock idling low and with it idling high. Input bits are captured on rising edges and output bits change on falling edges, most significant bit first.
- R4: Memory commands are followed by two address bytes, high byte first. The top three of the 16 address bits are ignored, so 0xE005 addresses byte 0x0005.
- R5: During a memory write, each byte is stored at the current address once its eighth bit is captured, and the address then advances by one. Any number of bytes may follow in one selection.
- R6: The address wraps from 0x1FFF to 0x0000 for both reads and writes.
- R7: During a memory read, the byte at the current address is shifted out, the address advances after each byte, and data on `spi_mosi` after the address has no effect.
- R8: `spi_miso_oe` is high only while memory data or the status byte is being shifted out and the link is selected and not held. It is low at reset and during every other phase.
- R9: A status read returns the `stat_rdata` value sampled when the command byte completes, for exactly one byte, after which the output is released. A status write gives one `stat_wr_stb` pulse carrying the next byte, and further bytes are ignored.
- R10: `prot_addr` presents the address of the byte in progress. A write byte for which `prot_grant` is low is discarded, but the address still advances.
- R11: A deselect in the middle of a byte discards the partial byte, and the next selection starts again at command decode.
- R12: While hold is in effect, clock and select edges are ignored and the output is released. Hold is entered or left only while the serial clock is low, and after release the transfer resumes at the same bit.
- R13: Deselecting after a memory-write or status-write command gives one `wr_op_end_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` |
| prot_addr | output | 13 | Address of the byte currently in transfer |
| prot_grant | input | 1 | Permission to store the byte at `prot_addr` |
| stat_rdata | input | 8 | Status byte provided by the protection unit |
| stat_wr_stb | output | 1 | Pulse carrying a written status byte |
| stat_wr_data | output | 8 | Status byte being written |
| wel_set_stb | output | 1 | Pulse requesting that the write latch be set |
| wel_clr_stb | output | 1 | Pulse requesting that the write latch be cleared |
| wr_op_end_stb | output | 1 | Pulse at the end of a write-type selection |

## Verification
The completion of a byte (the eighth rising clock edge) and a deselect can reach the sequencer in the same system-clock cycle. Deselect then wins, and the byte must not be stored. The bench provokes this by ending selections one or more bits into a data byte and right after full bytes. It then judges the outcome by reading back the neighbouring addresses against a reference array and by counting the strobe pulses. Hold release and clock edges also meet. The bench pauses reads and writes in the middle of a byte and toggles the clock during the pause, then checks that every bit lands unchanged.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
    localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
    localparam logic [7:0] CMD_STAT_GET  = 8'h05;
    localparam logic [7:0] CMD_STAT_PUT  = 8'h01;
    localparam logic [7:0] CMD_MEM_GET   = 8'h03;
    localparam logic [7:0] CMD_MEM_PUT   = 8'h02;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_IGNORE
    } seq_state_e;

endpackage

// File: rtl/spi_pin_front.sv
module spi_pin_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_start,
    output logic sel_end,
    output logic selected,
    output logic si_s,
    output logic held
);
    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] PIN_IDLE = 4'b1010; // hold_n, si, cs_n, sck

    logic [NPIN-1:0] stage_q [SYNC_STAGES];
    logic [NPIN-1:0] pins_s;
    logic sck_s, cs_s, hold_s;
    logic sck_d, cs_eff_n, cs_next;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= PIN_IDLE;
                end else if (g == 0) begin
                    stage_q[g] <= {hold_n, si, cs_n, sck};
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign pins_s = stage_q[SYNC_STAGES-1];
    assign sck_s  = pins_s[0];
    assign cs_s   = pins_s[1];
    assign si_s   = pins_s[2];
    assign hold_s = pins_s[3];

    assign cs_next   = held ? cs_eff_n : cs_s;
    assign sel_start = cs_eff_n && !cs_next;
    assign sel_end   = !cs_eff_n && cs_next;
    assign selected  = !cs_eff_n;
    assign sck_rise  = !held && !cs_eff_n && sck_s && !sck_d;
    assign sck_fall  = !held && !cs_eff_n && !sck_s && sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            cs_eff_n <= 1'b1;
            held     <= 1'b0;
        end else begin
            sck_d    <= sck_s;
            cs_eff_n <= cs_next;
            if (!sck_s) begin
                held <= !hold_s;
            end
        end
    end

    // R12
    hold_edge_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held != $past(held)) |-> !$past(sck_s));

endmodule

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              selected,
    input  logic              si_s,
    input  logic              held,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        stat_rdata,
    input  logic              wr_grant,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              miso,
    output logic              miso_oe,
    output logic              wel_set_stb,
    output logic              wel_clr_stb,
    output logic              stat_wr_stb,
    output logic [7:0]        stat_wr_data,
    output logic              wr_op_end_stb
);
    localparam int HI_W = ADDR_W - 8;

    seq_state_e        state, state_nxt;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sh;
    logic [7:0]        rx_byte;
    logic              byte_done;
    logic [ADDR_W-1:0] addr;
    logic [HI_W-1:0]   addr_hi;
    logic              mem_put_mode;
    logic              write_cmd_seen;
    logic [7:0]        stat_q;
    logic              miso_q;

    assign rx_byte   = {rx_sh, si_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7) && !sel_end;

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (sel_end || sel_start) begin
            state_nxt = ST_OPCODE;
        end else if (byte_done) begin
            unique case (state)
                ST_OPCODE: begin
                    if (rx_byte == CMD_MEM_GET || rx_byte == CMD_MEM_PUT)
                        state_nxt = ST_ADDR_HI;
                    else if (rx_byte == CMD_STAT_GET)
                        state_nxt = ST_STAT_RD;
                    else if (rx_byte == CMD_STAT_PUT)
                        state_nxt = ST_STAT_WR;
                    else
                        state_nxt = ST_IGNORE;
                end
                ST_ADDR_HI: state_nxt = ST_ADDR_LO;
                ST_ADDR_LO: state_nxt = mem_put_mode ? ST_MEM_WR : ST_MEM_RD;
                ST_MEM_WR:  state_nxt = ST_MEM_WR;
                ST_MEM_RD:  state_nxt = ST_MEM_RD;
                ST_STAT_RD: state_nxt = ST_IGNORE;
                ST_STAT_WR: state_nxt = ST_IGNORE;
                ST_IGNORE:  state_nxt = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OPCODE;
        end else begin
            state <= state_nxt;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt        <= '0;
            rx_sh          <= '0;
            addr           <= '0;
            addr_hi        <= '0;
            mem_put_mode   <= 1'b0;
            write_cmd_seen <= 1'b0;
            stat_q         <= '0;
            miso_q         <= 1'b0;
        end else begin
            if (sel_start || sel_end) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_sh   <= rx_byte[6:0];
            end
            if (sel_end) begin
                write_cmd_seen <= 1'b0;
            end
            if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        mem_put_mode   <= (rx_byte == CMD_MEM_PUT);
                        write_cmd_seen <= (rx_byte == CMD_MEM_PUT) || (rx_byte == CMD_STAT_PUT);
                        stat_q         <= stat_rdata;
                    end
                    ST_ADDR_HI: addr_hi <= rx_byte[HI_W-1:0];
                    ST_ADDR_LO: addr    <= {addr_hi, rx_byte};
                    ST_MEM_WR,
                    ST_MEM_RD:  addr    <= addr + 1'b1;
                    default: ;
                endcase
            end
            if (sck_fall) begin
                if (state == ST_STAT_RD) begin
                    miso_q <= stat_q[~bit_cnt];
                end else if (state == ST_MEM_RD) begin
                    miso_q <= mem_rdata[~bit_cnt];
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_we        = byte_done && (state == ST_MEM_WR) && wr_grant;
        mem_wdata     = rx_byte;
        mem_addr      = addr;
        wel_set_stb   = byte_done && (state == ST_OPCODE) && (rx_byte == CMD_LATCH_ON);
        wel_clr_stb   = byte_done && (state == ST_OPCODE) && (rx_byte == CMD_LATCH_OFF);
        stat_wr_stb   = byte_done && (state == ST_STAT_WR);
        stat_wr_data  = rx_byte;
        wr_op_end_stb = sel_end && write_cmd_seen;
        miso          = miso_q;
        miso_oe       = ((state == ST_MEM_RD) || (state == ST_STAT_RD)) && selected && !held;
    end

    // R11
    desel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_end |=> (state == ST_OPCODE) && (bit_cnt == 3'd0));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ((state == ST_MEM_WR) || (state == ST_MEM_RD)))
            |=> addr == ADDR_W'($past(addr) + 1'b1));

    // R12
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(state) && $stable(bit_cnt) && $stable(addr));

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wel_set_stb, wel_clr_stb, stat_wr_stb, mem_we, wr_op_end_stb}));

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl #(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] prot_addr,
    input  logic              prot_grant,
    input  logic [7:0]        stat_rdata,
    output logic              stat_wr_stb,
    output logic [7:0]        stat_wr_data,
    output logic              wel_set_stb,
    output logic              wel_clr_stb,
    output logic              wr_op_end_stb
);
    logic sck_rise, sck_fall, sel_start, sel_end, selected, si_s, held;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    spi_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .si        (spi_mosi),
        .hold_n    (spi_hold_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .selected  (selected),
        .si_s      (si_s),
        .held      (held)
    );

    spi_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_rise      (sck_rise),
        .sck_fall      (sck_fall),
        .sel_start     (sel_start),
        .sel_end       (sel_end),
        .selected      (selected),
        .si_s          (si_s),
        .held          (held),
        .mem_rdata     (mem_rdata),
        .stat_rdata    (stat_rdata),
        .wr_grant      (prot_grant),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .miso          (spi_miso),
        .miso_oe       (spi_miso_oe),
        .wel_set_stb   (wel_set_stb),
        .wel_clr_stb   (wel_clr_stb),
        .stat_wr_stb   (stat_wr_stb),
        .stat_wr_data  (stat_wr_data),
        .wr_op_end_stb (wr_op_end_stb)
    );

    spi_byte_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

    assign prot_addr = mem_addr;

    // R8
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> selected && !held);

    // R10
    grant_gates_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> prot_grant);

endmodule

// File: tb/spi_mem_ctrl_tb.sv
`timescale 1ns/1ps
module spi_mem_ctrl_tb;
    localparam int AW = 13;
    localparam time HALF = 40ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
    logic miso, miso_oe;
    logic [AW-1:0] prot_addr;
    logic prot_grant;
    logic [7:0] stat_val = 8'h8C;
    logic stat_wr_stb, wel_set_stb, wel_clr_stb, wr_op_end_stb;
    logic [7:0] stat_wr_data;

    always #2.5ns clk = ~clk;

    spi_mem_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .prot_addr(prot_addr), .prot_grant(prot_grant), .stat_rdata(stat_val),
        .stat_wr_stb(stat_wr_stb), .stat_wr_data(stat_wr_data),
        .wel_set_stb(wel_set_stb), .wel_clr_stb(wel_clr_stb), .wr_op_end_stb(wr_op_end_stb)
    );

    // protection unit model: latch plus upper-quarter guard
    logic wel_m = 1'b0;
    bit   prot_on = 1'b0;
    assign prot_grant = wel_m && !(prot_on && prot_addr >= 13'h1800);

    int n_set = 0, n_clr = 0, n_swr = 0, n_end = 0, n_oe = 0;
    logic [7:0] last_swr = 8'h00;
    always @(posedge clk) begin
        if (wel_set_stb) begin n_set++; wel_m <= 1'b1; end
        if (wel_clr_stb || wr_op_end_stb) wel_m <= 1'b0;
        if (wel_clr_stb) n_clr++;
        if (wr_op_end_stb) n_end++;
        if (stat_wr_stb) begin n_swr++; last_swr <= stat_wr_data; end
        if (miso_oe) n_oe++;
    end

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_last;
    event       rx_ev;
    initial forever begin
        @(rx_ev);
        if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected byte", int'(rx_last), 0);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(rx_last === e, t, int'(rx_last), int'(e));
        end
    end

    logic [7:0] ref_mem [1 << AW];
    bit mode3 = 1'b0;
    bit exp_wel = 1'b0;

    task automatic sel();
        sck = mode3; #HALF; cs_n = 1'b0; #HALF;
    endtask
    task automatic desel();
        if (!mode3) begin sck = 1'b0; #HALF; end
        cs_n = 1'b1; #(HALF * 3);
    endtask

    task automatic xfer(input logic [7:0] tx, input bit rd, input int hold_bit, input int nbits);
        logic [7:0] rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sck = 1'b0; mosi = tx[i]; #HALF;
            if (i == hold_bit) begin
                hold_n = 1'b0; #HALF;
                chk(miso_oe == 1'b0, "R12 oe during hold", int'(miso_oe), 0);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; mosi = ~mosi; #HALF; sck = 1'b0; #HALF;
                end
                mosi = tx[i]; hold_n = 1'b1; #HALF;
            end
            rx[i] = miso_oe ? miso : 1'b1;
            sck = 1'b1; #HALF;
        end
        if (rd) begin rx_last = rx; ->rx_ev; #1; end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string t);
        exp_q.push_back(v); tag_q.push_back(t);
    endtask

    task automatic simple_cmd(input logic [7:0] op);
        sel(); xfer(op, 1'b0, -1, 8); desel();
        if (op == 8'h06) exp_wel = 1'b1;
        if (op == 8'h04) exp_wel = 1'b0;
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] d [4], input int n, input int hold_bit);
        sel();
        xfer(8'h02, 1'b0, -1, 8); xfer(a[15:8], 1'b0, -1, 8); xfer(a[7:0], 1'b0, -1, 8);
        for (int k = 0; k < n; k++) begin
            automatic logic [AW-1:0] ak = AW'(a + k);
            automatic bit ok = exp_wel && !(prot_on && ak >= 13'h1800);
            xfer(d[k], 1'b0, (k == 0) ? hold_bit : -1, 8);
            if (ok) ref_mem[ak] = d[k];
        end
        desel();
        exp_wel = 1'b0;
    endtask

    task automatic mem_read(input logic [15:0] a, input int n, input int hold_bit, input string t);
        sel();
        xfer(8'h03, 1'b0, -1, 8); xfer(a[15:8], 1'b0, -1, 8); xfer(a[7:0], 1'b0, -1, 8);
        for (int k = 0; k < n; k++) begin
            expect_byte(ref_mem[AW'(a + k)], t);
            xfer(8'hA5 ^ 8'(k * 37), 1'b1, (k == 1) ? hold_bit : -1, 8);
        end
        desel();
    endtask

    initial begin
        #(150000 * 5ns);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int s0, c0, oe0, e0, w0;
        #50ns; rst_n = 1'b1; #50ns;
        // reset state: R8
        chk(miso_oe == 1'b0 && n_set == 0 && n_swr == 0, "R8 reset quiet", int'(miso_oe), 0);

        // R1 latch set / clear, both clock polarities (R3)
        mode3 = 0; simple_cmd(8'h06);
        chk(n_set == 1, "R1 set pulse", n_set, 1);
        mode3 = 1; simple_cmd(8'h04);
        chk(n_clr == 1, "R1 clear pulse", n_clr, 1);
        s0 = n_set; c0 = n_clr; oe0 = n_oe; w0 = n_swr;
        simple_cmd(8'h55);
        chk(n_set == s0 && n_clr == c0 && n_oe == oe0 && n_swr == w0, "R1 unknown code", n_set + n_clr, s0 + c0);

        // R2 one command per selection
        mode3 = 0; s0 = n_set;
        sel(); xfer(8'h06, 1'b0, -1, 8); xfer(8'h03, 1'b0, -1, 8); xfer(8'h00, 1'b0, -1, 8);
        xfer(8'h00, 1'b0, -1, 8);
        expect_byte(8'hFF, "R2 trailing bytes idle");
        xfer(8'h06, 1'b1, -1, 8);
        desel();
        chk(n_set == s0 + 1, "R2 single pulse", n_set, s0 + 1);
        simple_cmd(8'h04);

        // R9 status read in both polarities
        for (int m = 0; m < 2; m++) begin
            mode3 = m[0]; stat_val = 8'h8C ^ 8'(m);
            sel(); xfer(8'h05, 1'b0, -1, 8);
            expect_byte(stat_val, "R9 status read R3 polarity");
            xfer(8'h00, 1'b1, -1, 8);
            expect_byte(8'hFF, "R9 one status byte");
            xfer(8'h00, 1'b1, -1, 8);
            desel();
        end

        // R9 status write, R13 end pulse
        mode3 = 0; simple_cmd(8'h06);
        w0 = n_swr; e0 = n_end;
        sel(); xfer(8'h01, 1'b0, -1, 8); xfer(8'h3C, 1'b0, -1, 8); xfer(8'hC3, 1'b0, -1, 8); desel();
        chk(n_swr == w0 + 1, "R9 status write count", n_swr, w0 + 1);
        chk(last_swr == 8'h3C, "R9 status write data", int'(last_swr), 8'h3C);
        chk(n_end == e0 + 1, "R13 end pulse", n_end, e0 + 1);
        exp_wel = 1'b0;

        // R5 burst write mode 0, read back mode 3 (R3, R7); oe stays low while writing (R8)
        simple_cmd(8'h06);
        oe0 = n_oe;
        mem_write(16'h0100, '{8'h11, 8'h22, 8'h33, 8'h44}, 4, -1);
        chk(n_oe == oe0, "R8 no drive during write", n_oe, oe0);
        mode3 = 1; mem_read(16'h0100, 4, -1, "R5 R7 burst readback");

        // R4 top address bits ignored
        mode3 = 0; simple_cmd(8'h06);
        mem_write(16'hE005, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, -1);
        mem_read(16'h0005, 1, -1, "R4 masked address");

        // R6 wrap on write and read
        simple_cmd(8'h06);
        mem_write(16'h1FFE, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 4, -1);
        mode3 = 1; mem_read(16'h1FFE, 4, -1, "R6 wrap");
        mem_read(16'h0000, 2, -1, "R6 wrap landing");

        // R10 protected range and cleared latch
        mode3 = 0; simple_cmd(8'h06);
        mem_write(16'h17FE, '{8'h01, 8'h02, 8'h03, 8'h04}, 4, -1);
        prot_on = 1'b1; simple_cmd(8'h06);
        mem_write(16'h17FE, '{8'hF1, 8'hF2, 8'hF3, 8'hF4}, 4, -1);
        mem_read(16'h17FE, 4, -1, "R10 protected bytes dropped");
        prot_on = 1'b0;
        mem_write(16'h0100, '{8'hEE, 8'hEE, 8'h00, 8'h00}, 2, -1);
        mem_read(16'h0100, 2, -1, "R10 latch clear drops");

        // R11 partial byte then deselect
        simple_cmd(8'h06);
        sel(); xfer(8'h02, 1'b0, -1, 8); xfer(8'h01, 1'b0, -1, 8); xfer(8'h00, 1'b0, -1, 8);
        xfer(8'h77, 1'b0, -1, 8); ref_mem[13'h0100] = 8'h77;
        xfer(8'h99, 1'b0, -1, 4);
        desel(); exp_wel = 1'b0;
        mem_read(16'h0100, 2, -1, "R11 partial byte dropped");

        // R12 hold inside read and write bytes, both polarities
        for (int m = 0; m < 2; m++) begin
            mode3 = m[0]; simple_cmd(8'h06);
            mem_write(16'h0200, '{8'hC5 ^ 8'(m), 8'h6B, 8'h00, 8'h00}, 2, 3);
            mem_read(16'h0200, 2, 4, "R12 hold resume");
        end

        #200ns;
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule